// File: doc/BRIEF.md
# Transmission Error Supervisor

This block watches the data words that arrive over an internal isolation link, one transfer per scan trigger. Every transfer comes with a valid strobe and an error indication. A clean transfer is passed to the output. A corrupted one is dropped, and the output keeps showing the last word that arrived clean, so downstream logic never sees damaged data.

Two run counters track consecutive bad transfers and consecutive good transfers. When a run of bad transfers reaches a set length, a sustained-fault flag is raised. That flag is driven out as a reset request to the averaging filters. The flag is lowered only after a run of good transfers of the same length.

An active-low error output merges three things: the sustained-fault flag, a supply-missing status from outside, and an internal link-not-ready status. Link-not-ready is set from reset until the first clean transfer has arrived.

Top module: `tes_supervisor`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `word_out` is 0, `filter_rst` is 0 and `err_n` is 0.
- R2: A transfer counts only at a clock edge where `xfer_stb` is 1. It is clean when `xfer_bad` is 0. At that edge, a clean transfer loads `xfer_word` into `word_out`.
- R3: A transfer with `xfer_bad` = 1 leaves `word_out` at the last clean word.
- R4: `filter_rst` rises at the edge of the RUN_LEN-th consecutive bad transfer (default 4). Shorter runs of bad transfers leave it at 0.
- R5: Once set, `filter_rst` falls at the edge of the RUN_LEN-th consecutive clean transfer. A bad transfer in between restarts the clean run. A clean transfer restarts the bad run.
- R6: Cycles with `xfer_stb` = 0 change neither counter, nor `word_out`, nor `filter_rst`, whatever `xfer_bad` and `xfer_word` carry.
- R7: At each edge, `err_n` is registered as the inverse of the OR of the next fault flag, `supply_missing` and the next link-not-ready status.
- R8: The link-not-ready status is 1 from reset until the first clean transfer. While it is 1, `err_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_stb | input | 1 | One pulse per received transfer |
| xfer_bad | input | 1 | Transfer failed its check (used only when strobed) |
| xfer_word | input | DATA_W | Received data word |
| supply_missing | input | 1 | Sensor-side supply is absent |
| word_out | output | DATA_W | Last clean word |
| filter_rst | output | 1 | Sustained-fault flag, used as a filter reset request |
| err_n | output | 1 | Active-low merged error |

## Verification
A run counter in the wrong state does not show at once. It shows only when a run completes: `filter_rst` moves one transfer early or late, or fails to move at all. The bench therefore drives runs of exactly RUN_LEN-1, RUN_LEN and RUN_LEN+1 transfers, and runs broken by a transfer of the other kind. A wrong held word shows on `word_out` in the cycle after the next bad transfer. A wrong link-not-ready status or wrong error merge shows on `err_n` one edge after the input that should have moved it.

// File: rtl/tes_pkg.sv
package tes_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_GOOD = 2'd1,
    EV_BAD  = 2'd2
  } xfer_ev_e;
endpackage

// File: rtl/tes_event_decode.sv
module tes_event_decode (
  input  logic              stb,
  input  logic              bad,
  output tes_pkg::xfer_ev_e ev
);
  always_comb begin
    if (!stb)     ev = tes_pkg::EV_NONE;
    else if (bad) ev = tes_pkg::EV_BAD;
    else          ev = tes_pkg::EV_GOOD;
  end
endmodule

// File: rtl/tes_run_counter.sv
module tes_run_counter #(
  parameter int                RUN_LEN = 4,
  parameter tes_pkg::xfer_ev_e KIND    = tes_pkg::EV_GOOD
) (
  input  logic              clk,
  input  logic              rst,
  input  tes_pkg::xfer_ev_e ev,
  output logic              run_done
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] TOP = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  // run_done fires on the transfer that completes a run of this kind
  assign run_done = (ev == KIND) && (cnt_q >= TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ev == KIND) begin
      if (cnt_q < TOP) cnt_q <= cnt_q + 1'b1;
    end else if (ev != tes_pkg::EV_NONE) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/tes_word_hold.sv
module tes_word_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  tes_pkg::xfer_ev_e ev,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)                         word_q <= '0;
    else if (ev == tes_pkg::EV_GOOD) word_q <= word_in;
  end
endmodule

// File: rtl/tes_fault_merge.sv
module tes_fault_merge (
  input  logic              clk,
  input  logic              rst,
  input  tes_pkg::xfer_ev_e ev,
  input  logic              bad_run_done,
  input  logic              good_run_done,
  input  logic              supply_missing,
  output logic              flag_q,
  output logic              err_n_q
);
  logic lnr_q;
  logic flag_nxt;
  logic lnr_nxt;

  always_comb begin
    flag_nxt = flag_q;
    if (bad_run_done)       flag_nxt = 1'b1;
    else if (good_run_done) flag_nxt = 1'b0;
    lnr_nxt = lnr_q && (ev != tes_pkg::EV_GOOD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      lnr_q   <= 1'b1;
      err_n_q <= 1'b0;
    end else begin
      flag_q  <= flag_nxt;
      lnr_q   <= lnr_nxt;
      err_n_q <= ~(flag_nxt | supply_missing | lnr_nxt);
    end
  end
endmodule

// File: rtl/tes_supervisor.sv
module tes_supervisor #(
  parameter int DATA_W  = 8,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_stb,
  input  logic              xfer_bad,
  input  logic [DATA_W-1:0] xfer_word,
  input  logic              supply_missing,
  output logic [DATA_W-1:0] word_out,
  output logic              filter_rst,
  output logic              err_n
);
  tes_pkg::xfer_ev_e ev;
  logic [1:0]        run_done;

  tes_event_decode u_dec (
    .stb (xfer_stb),
    .bad (xfer_bad),
    .ev  (ev)
  );

  // index 0 counts clean transfers, index 1 counts bad ones
  for (genvar g = 0; g < 2; g++) begin : g_run
    localparam tes_pkg::xfer_ev_e KIND = (g == 0) ? tes_pkg::EV_GOOD : tes_pkg::EV_BAD;
    tes_run_counter #(.RUN_LEN(RUN_LEN), .KIND(KIND)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .ev       (ev),
      .run_done (run_done[g])
    );
  end

  tes_word_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev),
    .word_in (xfer_word),
    .word_q  (word_out)
  );

  tes_fault_merge u_merge (
    .clk            (clk),
    .rst            (rst),
    .ev             (ev),
    .bad_run_done   (run_done[1]),
    .good_run_done  (run_done[0]),
    .supply_missing (supply_missing),
    .flag_q         (filter_rst),
    .err_n_q        (err_n)
  );
endmodule

// File: rtl/tes_supervisor_checker.sv
module tes_supervisor_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_stb,
  input logic              xfer_bad,
  input logic [DATA_W-1:0] xfer_word,
  input logic              supply_missing,
  input logic [DATA_W-1:0] word_out,
  input logic              filter_rst,
  input logic              err_n
);
  logic seen_good;
  always_ff @(posedge clk) begin
    if (rst)                       seen_good <= 1'b0;
    else if (xfer_stb && !xfer_bad) seen_good <= 1'b1;
  end

  assert_good_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (xfer_stb && !xfer_bad) |=> (word_out == $past(xfer_word)));

  assert_bad_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (xfer_stb && xfer_bad) |=> $stable(word_out));

  assert_flag_rise_on_bad_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(filter_rst) |-> $past(xfer_stb && xfer_bad));

  assert_flag_fall_on_good_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(filter_rst) |-> $past(xfer_stb && !xfer_bad));

  assert_idle_no_change_R6: assert property (@(posedge clk) disable iff (rst)
    !xfer_stb |=> ($stable(word_out) && $stable(filter_rst)));

  assert_supply_forces_err_R7: assert property (@(posedge clk) disable iff (rst)
    supply_missing |=> !err_n);

  assert_not_ready_forces_err_R8: assert property (@(posedge clk) disable iff (rst)
    !seen_good |-> !err_n);
endmodule

bind tes_supervisor tes_supervisor_checker #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .xfer_stb       (xfer_stb),
  .xfer_bad       (xfer_bad),
  .xfer_word      (xfer_word),
  .supply_missing (supply_missing),
  .word_out       (word_out),
  .filter_rst     (filter_rst),
  .err_n          (err_n)
);

// File: tb/test_tes_supervisor.sv
module test_tes_supervisor;
  localparam int W   = 8;
  localparam int RUN = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         stb = 1'b0;
  logic         bad = 1'b0;
  logic [W-1:0] word = '0;
  logic         sm = 1'b0;
  logic [W-1:0] word_out;
  logic         filter_rst;
  logic         err_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  int           m_bad_run  = 0;
  int           m_good_run = 0;
  bit           m_flag     = 0;
  bit           m_lnr      = 1;
  bit           m_errn     = 0;
  logic [W-1:0] m_word     = '0;

  always #2.5 clk = ~clk;

  tes_supervisor #(.DATA_W(W), .RUN_LEN(RUN)) i_tes_supervisor (
    .clk (clk), .rst (rst), .xfer_stb (stb), .xfer_bad (bad),
    .xfer_word (word), .supply_missing (sm),
    .word_out (word_out), .filter_rst (filter_rst), .err_n (err_n)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_bad_run = 0; m_good_run = 0; m_flag = 0; m_lnr = 1; m_word = '0;
      m_errn = 0;
    end else begin
      if (stb && bad) begin
        m_bad_run++; m_good_run = 0;
        if (m_bad_run >= RUN) m_flag = 1;
      end else if (stb) begin
        m_good_run++; m_bad_run = 0; m_word = word; m_lnr = 0;
        if (m_good_run >= RUN) m_flag = 0;
      end
      m_errn = !(m_flag || sm || m_lnr);
    end
    #1;
    // word path: R2 clean load, R3 hold on bad, R6 idle ignore
    chk("R2 R3 R6 word_out", word_out, m_word);
    // fault flag: R4 set run, R5 clear run, R6 idle ignore
    chk("R4 R5 R6 filter_rst", W'(filter_rst), W'(m_flag));
    // error merge: R1 reset, R7 merge, R8 startup release
    chk("R1 R7 R8 err_n", W'(err_n), W'(m_errn));
  end

  task automatic xfer(input bit s, input bit b, input logic [W-1:0] d, input bit sup);
    @(negedge clk);
    stb = s; bad = b; word = d; sm = sup;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values while reset is held
    chk("R1 reset word", word_out, '0);
    chk("R1 reset flag", W'(filter_rst), '0);
    chk("R1 reset err_n", W'(err_n), '0);
    rst = 1'b0;
    // R8: bad transfers and idles before the first clean one keep err_n low
    xfer(1, 1, 8'h11, 0);
    xfer(0, 0, 8'h22, 0);
    xfer(1, 0, 8'hA5, 0);            // first clean word releases startup
    xfer(0, 0, 8'h00, 0);
    @(negedge clk);
    chk("R8 released err_n", W'(err_n), 1);
    chk("R2 first word", word_out, 8'hA5);
    // R4: three bad, one good, then exactly four bad
    for (int i = 0; i < RUN-1; i++) xfer(1, 1, 8'hF0 + W'(i), 0);
    xfer(1, 0, 8'h3C, 0);
    for (int i = 0; i < RUN; i++) xfer(1, 1, 8'hE0 + W'(i), 0);
    xfer(0, 1, 8'hFF, 0);
    @(negedge clk);
    chk("R4 flag after run", W'(filter_rst), 1);
    chk("R3 held word", word_out, 8'h3C);
    // R6: idle cycles with junk on the inputs
    for (int i = 0; i < 5; i++) xfer(0, i[0], 8'h77, 0);
    // R5: three good, one bad, then four good
    for (int i = 0; i < RUN-1; i++) xfer(1, 0, 8'h40 + W'(i), 0);
    xfer(1, 1, 8'h99, 0);
    for (int i = 0; i < RUN-1; i++) xfer(1, 0, 8'h50 + W'(i), 0);
    xfer(0, 0, 8'h00, 0);
    @(negedge clk);
    chk("R5 still set", W'(filter_rst), 1);
    xfer(1, 0, 8'h5F, 0);
    xfer(0, 0, 8'h00, 0);
    @(negedge clk);
    chk("R5 cleared", W'(filter_rst), 0);
    // R7: supply missing pulses
    xfer(0, 0, 8'h00, 1);
    xfer(1, 0, 8'h61, 1);
    xfer(0, 0, 8'h00, 0);
    @(negedge clk);
    chk("R7 err_n back high", W'(err_n), 1);
    // mixed pattern from an LFSR
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        xfer(lf[0] | lf[1], lf[2] & (lf[3] | lf[9]), lf[15:8], lf[4] & lf[5] & lf[6]);
      end
    end
    // reset again mid-stream: R1
    xfer(1, 1, 8'h12, 0);
    rst = 1'b1;
    xfer(0, 0, 8'h00, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after reset word", word_out, '0);
    chk("R1 after reset err_n", W'(err_n), 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule